// File: doc/BRIEF.md
# Configurable External Interrupt Sense Unit

This block watches a single external interrupt pin and raises an interrupt request according to a two-bit sense mode. The four modes are low level, any edge, falling edge and rising edge. The pin value is used whichever way the pin is driven, so a pin driven as an output by the chip can still raise an interrupt. Software can use that path to trigger an interrupt of its own.

The edge modes resample the pin through a clocked synchronizer. They then compare the newest synchronized sample with the one before it and record a match in a sticky flag. A write-one clear or an acknowledge removes the flag. Edge detection depends on the I/O clock, which is represented here by a clock-running input. While that input is low, the sampling registers hold and no edges are seen. The I/O clock is stopped in every sleep state except the lightest one. Low-level sensing is therefore the only mode that can wake the device from the deeper states.

Low-level sensing is purely combinational and stores no flag. It drives a wake request with no clock present. It raises the interrupt request only while a start-up-done input is high. If the pin returns high before start-up ends, the device still wakes, but it takes no interrupt. A change of sense mode never records a flag on the cycle of the change.

Top module: `eis_sense_unit`

## Requirements
- R1: The sense mode encoding is 00 low level, 01 any edge, 10 falling edge and 11 rising edge. In an edge mode the flag is set only by a transition of the matching direction.
- R2: A pin change made while the clock runs sets flag_o after the third rising clock edge that follows it. This is two synchronizer stages plus the flag register. flag_o is still low after the second edge.
- R3: In mode 00, irq_o is high in every cycle in which enable is high, the pin is low and startup_done_i is high. The request is level-based and is not a one-shot.
- R4: In mode 00, wake_o is high combinationally whenever enable is high and the pin is low, whatever the values of clk_run_i and startup_done_i.
- R5: In mode 00, irq_o stays low while startup_done_i is low.
- R6: While clk_run_i is low, no edge is recorded and flag_o keeps its value.
- R7: The flag is sticky until flag_clr_i or ack_i is high at a running clock edge. An edge detected in the same cycle as a clear wins, and the flag stays set.
- R8: No flag is set at a clock edge where the sense mode differs from the mode held at the previous running edge.
- R9: With enable low, irq_o and wake_o are low. An edge that matches the mode still sets flag_o, and raising enable then gives irq_o = 1.
- R10: In mode 00 the flag is cleared at the next running clock edge and is not set again while that mode stays selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | External interrupt pin level |
| sense_mode_i | input | 2 | Sense mode: 00 low, 01 any, 10 fall, 11 rise |
| enable_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one clear of the edge flag |
| ack_i | input | 1 | Interrupt acknowledge, also clears the flag |
| clk_run_i | input | 1 | High while the I/O clock is running |
| startup_done_i | input | 1 | High once wake-up start-up has ended |
| flag_o | output | 1 | Sticky edge flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
A synchronizer stage stuck at a wrong value or shifted by one shows up as flag_o rising one cycle early or late. This is caught at the third edge after a pin change. A wrong previous-sample register or mode-tracking register shows up as a flag set on a mode switch, or as a flag set for the wrong direction, within one clock. A fault in the level path shows up as irq_o or wake_o at once, in the same cycle, against a per-cycle reference model.

// File: rtl/eis_pkg.sv
package eis_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef struct packed {
        logic older;
        logic newer;
    } pin_pair_t;

    typedef struct packed {
        logic wake;
        logic irq;
    } req_t;

    function automatic logic edge_match(sense_e mode, pin_pair_t pp);
        logic hit;
        case (mode)
            SENSE_ANY:  hit = pp.older ^ pp.newer;
            SENSE_FALL: hit = pp.older & ~pp.newer;
            SENSE_RISE: hit = ~pp.older & pp.newer;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[g] <= RST_VAL;
            end else if (adv) begin
                if (g == 0) chain[g] <= d;
                else        chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/eis_edge_flag.sv
module eis_edge_flag
    import eis_pkg::*;
#(
    parameter logic RST_VAL = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    input  sense_e mode,
    input  logic   sync_in,
    input  logic   clr,
    output logic   flag
);
    logic      prev_q;
    sense_e    mode_q;
    pin_pair_t pair;
    logic      mode_same;
    logic      hit;

    assign pair      = '{older: prev_q, newer: sync_in};
    assign mode_same = (mode == mode_q);
    assign hit       = mode_same && edge_match(mode, pair);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= RST_VAL;
            mode_q <= SENSE_LOW;
        end else if (adv) begin
            // reload on every running edge, including a mode switch
            prev_q <= sync_in;
            mode_q <= mode;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (adv) begin
            if (mode == SENSE_LOW) flag <= 1'b0;
            else if (hit)          flag <= 1'b1;
            else if (clr)          flag <= 1'b0;
        end
    end
endmodule

// File: rtl/eis_level_path.sv
module eis_level_path
    import eis_pkg::*;
(
    input  sense_e mode,
    input  logic   enable,
    input  logic   pin,
    input  logic   startup_done,
    input  logic   flag,
    output req_t   req
);
    logic level_hit;
    logic edge_req;

    assign level_hit = (mode == SENSE_LOW) && enable && !pin;
    assign edge_req  = (mode != SENSE_LOW) && enable && flag;

    always_comb begin
        req.wake = level_hit | edge_req;
        req.irq  = (level_hit & startup_done) | edge_req;
    end
endmodule

// File: rtl/eis_sense_unit.sv
module eis_sense_unit
    import eis_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LEVEL  = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_i,
    input  logic [1:0] sense_mode_i,
    input  logic       enable_i,
    input  logic       flag_clr_i,
    input  logic       ack_i,
    input  logic       clk_run_i,
    input  logic       startup_done_i,
    output logic       flag_o,
    output logic       irq_o,
    output logic       wake_o
);
    sense_e mode;
    logic   pin_sync;
    logic   flag;
    req_t   req;

    assign mode = sense_e'(sense_mode_i);

    eis_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVEL)) u_sync (
        .clk (clk),
        .rst (rst),
        .adv (clk_run_i),
        .d   (pin_i),
        .q   (pin_sync)
    );

    eis_edge_flag #(.RST_VAL(IDLE_LEVEL)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .adv     (clk_run_i),
        .mode    (mode),
        .sync_in (pin_sync),
        .clr     (flag_clr_i | ack_i),
        .flag    (flag)
    );

    eis_level_path u_level (
        .mode         (mode),
        .enable       (enable_i),
        .pin          (pin_i),
        .startup_done (startup_done_i),
        .flag         (flag),
        .req          (req)
    );

    assign flag_o = flag;
    assign irq_o  = req.irq;
    assign wake_o = req.wake;
endmodule

// File: rtl/eis_sense_unit_chk.sv
module eis_sense_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       pin_i,
    input logic [1:0] sense_mode_i,
    input logic       enable_i,
    input logic       flag_clr_i,
    input logic       ack_i,
    input logic       clk_run_i,
    input logic       startup_done_i,
    input logic       flag_o,
    input logic       irq_o,
    input logic       wake_o
);
    logic [1:0] seen_mode;

    always_ff @(posedge clk) begin
        if (rst)            seen_mode <= 2'b00;
        else if (clk_run_i) seen_mode <= sense_mode_i;
    end

    assert_level_irq_R3: assert property (@(posedge clk) disable iff (rst)
        (sense_mode_i == 2'b00 && enable_i && !pin_i && startup_done_i) |-> irq_o);

    assert_level_wake_R4: assert property (@(posedge clk) disable iff (rst)
        (sense_mode_i == 2'b00 && enable_i && !pin_i) |-> wake_o);

    assert_startup_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (sense_mode_i == 2'b00 && !startup_done_i) |-> !irq_o);

    assert_clock_halt_R6: assert property (@(posedge clk) disable iff (rst)
        !clk_run_i |=> $stable(flag_o));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !flag_clr_i && !ack_i && sense_mode_i != 2'b00) |=> flag_o);

    assert_mode_switch_R8: assert property (@(posedge clk) disable iff (rst)
        (clk_run_i && sense_mode_i != seen_mode && !flag_o) |=> !flag_o);

    assert_enable_gate_R9: assert property (@(posedge clk) disable iff (rst)
        !enable_i |-> (!irq_o && !wake_o));

    assert_level_noflag_R10: assert property (@(posedge clk) disable iff (rst)
        (clk_run_i && sense_mode_i == 2'b00) |=> !flag_o);
endmodule

bind eis_sense_unit eis_sense_unit_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .pin_i          (pin_i),
    .sense_mode_i   (sense_mode_i),
    .enable_i       (enable_i),
    .flag_clr_i     (flag_clr_i),
    .ack_i          (ack_i),
    .clk_run_i      (clk_run_i),
    .startup_done_i (startup_done_i),
    .flag_o         (flag_o),
    .irq_o          (irq_o),
    .wake_o         (wake_o)
);

// File: tb/eis_sense_unit_test.sv
`timescale 1ns/100ps
module eis_sense_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       en = 1'b0, clr = 1'b0, ack = 1'b0, run = 1'b1, su = 1'b1;
    logic       flag_o, irq_o, wake_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    eis_sense_unit uut (
        .clk(clk), .rst(rst), .pin_i(pin), .sense_mode_i(mode),
        .enable_i(en), .flag_clr_i(clr), .ack_i(ack), .clk_run_i(run),
        .startup_done_i(su), .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    // behavioural reference: pin history delayed by two running edges
    logic       hist[$];
    logic       last_seen;
    logic [1:0] last_mode;
    logic       m_flag;

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            hist = {1'b1, 1'b1};
            last_seen = 1'b1;
            last_mode = 2'b00;
            m_flag = 1'b0;
        end else if (run) begin
            logic cur;
            logic hit;
            cur = hist[0];
            hit = 1'b0;
            if (mode == last_mode) begin
                if (mode == 2'b01) hit = (cur != last_seen);
                if (mode == 2'b10) hit = last_seen && !cur;
                if (mode == 2'b11) hit = !last_seen && cur;
            end
            if (mode == 2'b00)     m_flag = 1'b0;
            else if (hit)          m_flag = 1'b1;
            else if (clr || ack)   m_flag = 1'b0;
            last_seen = cur;
            last_mode = mode;
            void'(hist.pop_front());
            hist.push_back(pin);
        end
        #0.5;
        if (!rst) begin
            logic lvl;
            logic er;
            lvl = (mode == 2'b00) && en && !pin;
            er  = (mode != 2'b00) && en && m_flag;
            check("R7 flag model", flag_o, m_flag);
            check("R3 irq model", irq_o, er || (lvl && su));
            check("R4 wake model", wake_o, er || lvl);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        step(3);
        check("R9 reset flag", flag_o, 1'b0);
        check("R9 reset irq", irq_o, 1'b0);
        rst = 1'b0;
        step(2);

        // R1 falling mode, R2 latency
        en = 1'b1; mode = 2'b10;
        step(3);
        pin = 1'b0;
        step(2);
        check("R2 not yet after two edges", flag_o, 1'b0);
        step(1);
        check("R2 flag after third edge", flag_o, 1'b1);
        check("R1 falling irq", irq_o, 1'b1);
        clr = 1'b1; step(1); clr = 1'b0;
        check("R7 write-one clear", flag_o, 1'b0);

        // R1 rising mode ignores fall, sees rise
        mode = 2'b11; step(3);
        pin = 1'b1; step(3);
        check("R1 rising seen", flag_o, 1'b1);
        ack = 1'b1; step(1); ack = 1'b0;
        check("R7 ack clear", flag_o, 1'b0);
        pin = 1'b0; step(4);
        check("R1 falling ignored in rise mode", flag_o, 1'b0);

        // R1 any edge, R7 set beats clear
        mode = 2'b01; step(3);
        clr = 1'b1; pin = 1'b1; step(3);
        check("R7 set wins over clear", flag_o, 1'b1);
        step(1); clr = 1'b0;
        check("R7 clear next cycle", flag_o, 1'b0);
        pin = 1'b0; step(3);
        check("R1 any edge fall", flag_o, 1'b1);
        ack = 1'b1; step(1); ack = 1'b0;

        // R6 clock halted
        run = 1'b0; pin = 1'b1; step(5);
        check("R6 no edge while halted", flag_o, 1'b0);
        check("R6 no wake in edge mode", wake_o, 1'b0);
        run = 1'b1; step(4);
        flag_clr_pulse();

        // R8 mode switch on cycle the synced edge appears
        mode = 2'b11; pin = 1'b1; step(4);
        pin = 1'b0; step(2);
        mode = 2'b10; step(1);
        check("R8 no flag on mode switch", flag_o, 1'b0);
        step(3);
        check("R8 still no flag", flag_o, 1'b0);

        // R9 enable low still records
        en = 1'b0; pin = 1'b1; step(1); pin = 1'b0; step(3);
        check("R9 flag set with enable low", flag_o, 1'b1);
        check("R9 irq gated", irq_o, 1'b0);
        check("R9 wake gated", wake_o, 1'b0);
        en = 1'b1; #0.2;
        check("R9 irq after enable", irq_o, 1'b1);

        // R10, R3, R4, R5 low level
        mode = 2'b00; step(1);
        check("R10 flag cleared in level mode", flag_o, 1'b0);
        su = 1'b0; pin = 1'b0; #0.2;
        check("R5 irq held off", irq_o, 1'b0);
        check("R4 wake before startup", wake_o, 1'b1);
        run = 1'b0; #0.2;
        check("R4 wake without clock", wake_o, 1'b1);
        su = 1'b1; #0.2;
        check("R3 irq after startup", irq_o, 1'b1);
        step(3);
        check("R3 level held", irq_o, 1'b1);
        pin = 1'b1; #0.2;
        check("R3 released", irq_o, 1'b0);
        run = 1'b1; pin = 1'b0; step(3); pin = 1'b1; step(3);
        check("R10 no flag in level mode", flag_o, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic flag_clr_pulse();
        clr = 1'b1; step(1); clr = 1'b0;
    endtask

    initial begin
        #40000;
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule